// File: doc/BRIEF.md
# Relay-Style Register File Controller

This block holds twelve 10-bit registers behind a shared data bus and runs copy operations between them. A copy names a source and a destination with 4-bit select codes. Two identical decoders, one per code, turn the codes into per-register enable and clear strobes, and matching strobes from both decoders are ORed onto each register. Every write is a fixed three-phase sequence: the destination is cleared, it then follows the bus while its clear is still held, and the value present at the end of that window is the one kept. Bus activity earlier in the window therefore has no effect on the stored value.

Code 0 selects nothing. Codes 1 to 12 are physical registers. An instruction's 3-bit register field reaches only codes 1 to 7, and microcode reaches the rest. Code 10 is the instruction register, code 8 the jump base and code 12 the status register. The status register can be written but is never driven onto the bus. Codes 13 to 15 are read-only virtual sources that carry the three digit groups of an external binary-to-7-segment encoder. Writing one of them as a destination sets that encoder's display mode. Two flags are always present: a no-operation flag on the instruction register and a jump-base-in-use flag.

Top module: `relay_regfile`

## Requirements
- R1: After synchronous reset, every register, both mode outputs and `busy` are 0, `nop_flag` is 1 and `jb_used` is 0.
- R2: A `copy_req` sampled while `busy` is 0 latches both codes, and `busy` is then high for exactly three cycles. When the sequence ends, a destination with code 1 to 12 holds `ext_bus` sampled in the last load cycle, ORed with the source value. For codes 1 to 11 the source value is the register contents at acceptance.
- R3: The destination register reads as zero after the first phase edge, which is the clear phase. Values on `ext_bus` before the load cycle do not reach the stored result.
- R4: A copy whose source and destination codes are the same, with `ext_bus` at 0, leaves that register unchanged.
- R5: Source code 12 (status) and source code 0 contribute zero to the bus.
- R6: Source codes 13, 14 and 15 place `seg_hi`, `seg_mid` and `seg_lo` on the bus, ORed with `ext_bus`.
- R7: Destination 13 sets `enc_signed` and clears `enc_hex`. Destination 14 sets `enc_hex`. Destination 15 clears both. Destination 0 changes nothing. The mode bits change only while `busy` is high.
- R8: A `copy_req` sampled while `busy` is high is ignored.
- R9: `nop_flag` is 1 exactly when the instruction register (code 10) is all zeros or all ones.
- R10: `jb_used` is 1 exactly when any bit of the jump base register (code 8) is 1.
- R11: While `busy` is 0, `bus_out` equals `ext_bus`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| copy_req | input | 1 | Start a copy when idle |
| src_code | input | 4 | Source select code |
| dst_code | input | 4 | Destination select code |
| ext_bus | input | 10 | Value that other agents drive onto the bus |
| seg_hi | input | 10 | Encoder digit group, most significant (code 13) |
| seg_mid | input | 10 | Encoder digit group, middle (code 14) |
| seg_lo | input | 10 | Encoder digit group, least significant (code 15) |
| busy | output | 1 | Copy sequence in progress |
| bus_out | output | 10 | Data bus value |
| ir_q | output | 10 | Instruction register contents |
| status_q | output | 10 | Status register contents |
| nop_flag | output | 1 | Instruction register is all zeros or all ones |
| jb_used | output | 1 | Jump base register is nonzero |
| enc_signed | output | 1 | Encoder signed mode |
| enc_hex | output | 1 | Encoder hex mode |

## Verification
Two situations are hard to reach from the ports. One is the clear phase of a write, where the destination is empty. The other is a bus value that changes inside the write window. The stimulus drives a distinct glitch value on `ext_bus` during the clear cycle and a different final value in the load cycle, then reads the destination back through a second copy. For the instruction register it also samples `ir_q` in the middle of the clear phase. A self-copy and a request held high across the busy window are driven directly, because random codes seldom produce them.

// File: rtl/relay_rf_pkg.sv
package relay_rf_pkg;
    parameter int DATA_W    = 10;
    parameter int CODE_W    = 4;
    parameter int NUM_CODES = 1 << CODE_W;
    parameter int NUM_PHYS  = 12;

    localparam int CODE_JBASE   = 8;
    localparam int CODE_INSTR   = 10;
    localparam int CODE_STATUS  = 12;
    localparam int CODE_SEG_HI  = 13;
    localparam int CODE_SEG_MID = 14;
    localparam int CODE_SEG_LO  = 15;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_LOAD  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [NUM_CODES-1:1] en;
        logic [NUM_CODES-1:1] clr;
    } strobe_t;

    function automatic logic is_readable_phys(input int c);
        return (c >= 1) && (c <= NUM_PHYS) && (c != CODE_STATUS);
    endfunction
endpackage

// File: rtl/rf_sequencer.sv
module rf_sequencer
    import relay_rf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  code_t  src_in,
    input  code_t  dst_in,
    output phase_e phase,
    output code_t  src_q,
    output code_t  dst_q,
    output logic   accept
);
    assign accept = req && (phase == PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            src_q <= '0;
            dst_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase <= PH_CLEAR;
                        src_q <= src_in;
                        dst_q <= dst_in;
                    end
                end
                PH_CLEAR: phase <= PH_LOAD;
                PH_LOAD:  phase <= PH_HOLD;
                default:  phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rf_code_decoder.sv
module rf_code_decoder
    import relay_rf_pkg::*;
#(
    parameter bit IS_DEST = 1'b0
) (
    input  phase_e  phase,
    input  code_t   code,
    output strobe_t strb
);
    logic clear_win;
    logic load_win;

    assign load_win = (phase == PH_LOAD);

    generate
        if (IS_DEST) begin : g_dest
            assign clear_win = (phase == PH_CLEAR) || (phase == PH_LOAD);
        end else begin : g_src
            assign clear_win = 1'b0;
        end
    endgenerate

    always_comb begin
        strb.en  = '0;
        strb.clr = '0;
        for (int c = 1; c < NUM_CODES; c++) begin
            if (int'(code) == c) begin
                strb.en[c]  = load_win;
                strb.clr[c] = clear_win;
            end
        end
    end
endmodule

// File: rtl/rf_level_detect.sv
module rf_level_detect #(
    parameter int W        = 10,
    parameter bit NOP_MODE = 1'b1
) (
    input  logic [W-1:0] value,
    output logic         flag
);
    logic all_zero;
    assign all_zero = ~|value;

    generate
        if (NOP_MODE) begin : g_nop
            logic all_one;
            assign all_one = &value;
            assign flag    = all_zero ^ all_one;
        end else begin : g_any
            assign flag = ~all_zero;
        end
    endgenerate
endmodule

// File: rtl/relay_regfile.sv
module relay_regfile
    import relay_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              copy_req,
    input  logic [CODE_W-1:0] src_code,
    input  logic [CODE_W-1:0] dst_code,
    input  logic [DATA_W-1:0] ext_bus,
    input  logic [DATA_W-1:0] seg_hi,
    input  logic [DATA_W-1:0] seg_mid,
    input  logic [DATA_W-1:0] seg_lo,
    output logic              busy,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] status_q,
    output logic              nop_flag,
    output logic              jb_used,
    output logic              enc_signed,
    output logic              enc_hex
);
    phase_e  phase;
    code_t   src_q;
    code_t   dst_q;
    logic    accept;
    strobe_t src_strb;
    strobe_t dst_strb;
    strobe_t strb;
    word_t   regs [NUM_PHYS];
    word_t   snap_d;
    word_t   snap_q;
    word_t   src_val;

    rf_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .req    (copy_req),
        .src_in (src_code),
        .dst_in (dst_code),
        .phase  (phase),
        .src_q  (src_q),
        .dst_q  (dst_q),
        .accept (accept)
    );

    rf_code_decoder #(.IS_DEST(1'b0)) u_src_dec (
        .phase (phase),
        .code  (src_q),
        .strb  (src_strb)
    );

    rf_code_decoder #(.IS_DEST(1'b1)) u_dst_dec (
        .phase (phase),
        .code  (dst_q),
        .strb  (dst_strb)
    );

    // Wired-OR of the two decoders onto shared per-code strobes
    assign strb.en  = src_strb.en  | dst_strb.en;
    assign strb.clr = src_strb.clr | dst_strb.clr;

    assign busy = (phase != PH_IDLE);

    // Source value captured before any clear, so a self-copy survives
    always_comb begin
        snap_d = '0;
        for (int k = 0; k < NUM_PHYS; k++) begin
            if ((int'(src_code) == k + 1) && is_readable_phys(k + 1)) begin
                snap_d = regs[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (accept) begin
            snap_q <= snap_d;
        end
    end

    always_comb begin
        if (int'(src_q) == CODE_SEG_HI) begin
            src_val = seg_hi;
        end else if (int'(src_q) == CODE_SEG_MID) begin
            src_val = seg_mid;
        end else if (int'(src_q) == CODE_SEG_LO) begin
            src_val = seg_lo;
        end else begin
            src_val = snap_q;
        end
    end

    assign bus_out = ext_bus | (busy ? src_val : '0);

    // Clear alone empties the cell; clear with enable makes it follow the bus
    generate
        for (genvar k = 0; k < NUM_PHYS; k++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[k] <= '0;
                end else if (strb.clr[k+1]) begin
                    regs[k] <= strb.en[k+1] ? bus_out : '0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_signed <= 1'b0;
            enc_hex    <= 1'b0;
        end else begin
            if (strb.clr[CODE_SEG_HI] && !strb.en[CODE_SEG_HI]) begin
                enc_hex <= 1'b0;
            end
            if (strb.clr[CODE_SEG_HI] && strb.en[CODE_SEG_HI]) begin
                enc_signed <= 1'b1;
            end
            if (strb.clr[CODE_SEG_MID] && strb.en[CODE_SEG_MID]) begin
                enc_hex <= 1'b1;
            end
            if (strb.clr[CODE_SEG_LO] && strb.en[CODE_SEG_LO]) begin
                enc_signed <= 1'b0;
                enc_hex    <= 1'b0;
            end
        end
    end

    assign ir_q     = regs[CODE_INSTR-1];
    assign status_q = regs[CODE_STATUS-1];

    rf_level_detect #(.W(DATA_W), .NOP_MODE(1'b1)) u_nop_det (
        .value (regs[CODE_INSTR-1]),
        .flag  (nop_flag)
    );

    rf_level_detect #(.W(DATA_W), .NOP_MODE(1'b0)) u_jb_det (
        .value (regs[CODE_JBASE-1]),
        .flag  (jb_used)
    );
endmodule

// File: rtl/relay_regfile_chk.sv
module relay_regfile_chk
    import relay_rf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              copy_req,
    input logic [CODE_W-1:0] dst_code,
    input logic [DATA_W-1:0] ext_bus,
    input logic              busy,
    input logic [DATA_W-1:0] bus_out,
    input logic [DATA_W-1:0] ir_q,
    input logic [DATA_W-1:0] status_q,
    input logic              nop_flag,
    input logic              enc_signed,
    input logic              enc_hex
);
    assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    assert_reg_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(ir_q) && $stable(status_q)));

    assert_ir_cleared_R3: assert property (@(posedge clk) disable iff (rst)
        (copy_req && !busy && (int'(dst_code) == CODE_INSTR)) |=> ##1 (ir_q == '0));

    assert_mode_idle_stable_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(enc_signed) && $stable(enc_hex)));

    assert_nop_level_R9: assert property (@(posedge clk) disable iff (rst)
        nop_flag == ((ir_q == '0) || (ir_q == '1)));

    assert_bus_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bus_out == ext_bus));
endmodule

bind relay_regfile relay_regfile_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .copy_req   (copy_req),
    .dst_code   (dst_code),
    .ext_bus    (ext_bus),
    .busy       (busy),
    .bus_out    (bus_out),
    .ir_q       (ir_q),
    .status_q   (status_q),
    .nop_flag   (nop_flag),
    .enc_signed (enc_signed),
    .enc_hex    (enc_hex)
);

// File: tb/relay_regfile_tb_top.sv
`timescale 1ns/1ps
module relay_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       copy_req = 1'b0;
    logic [3:0] src_code = '0;
    logic [3:0] dst_code = '0;
    logic [9:0] ext_bus = '0;
    logic [9:0] seg_hi = '0;
    logic [9:0] seg_mid = '0;
    logic [9:0] seg_lo = '0;
    logic       busy;
    logic [9:0] bus_out;
    logic [9:0] ir_q;
    logic [9:0] status_q;
    logic       nop_flag;
    logic       jb_used;
    logic       enc_signed;
    logic       enc_hex;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [9:0] m [1:12];
    logic       m_sig = 1'b0;
    logic       m_hex = 1'b0;

    always #4 clk = ~clk;

    relay_regfile dut_i (
        .clk(clk), .rst(rst), .copy_req(copy_req),
        .src_code(src_code), .dst_code(dst_code), .ext_bus(ext_bus),
        .seg_hi(seg_hi), .seg_mid(seg_mid), .seg_lo(seg_lo),
        .busy(busy), .bus_out(bus_out), .ir_q(ir_q), .status_q(status_q),
        .nop_flag(nop_flag), .jb_used(jb_used),
        .enc_signed(enc_signed), .enc_hex(enc_hex)
    );

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] src_model(input int c);
        if (c >= 1 && c <= 11) return m[c];
        if (c == 13) return seg_hi;
        if (c == 14) return seg_mid;
        if (c == 15) return seg_lo;
        return '0;  // code 0 and status code 12 (R5)
    endfunction

    function automatic logic nop_model(input logic [9:0] v);
        return (v == 10'h000) || (v == 10'h3FF);
    endfunction

    // Full copy: glitch value on ext_bus in the clear cycle, final value in the load cycle
    task automatic do_copy(input int s, input int d, input logic [9:0] fin,
                           input logic [9:0] glitch, input bit hold_req, input int hold_dst);
        logic [9:0] v;
        v = fin | src_model(s);
        @(negedge clk);
        src_code = 4'(s); dst_code = 4'(d); copy_req = 1'b1; ext_bus = glitch;
        @(posedge clk);
        @(negedge clk);
        chk("R2 busy after accept", 10'(busy), 10'd1);
        copy_req = hold_req; dst_code = 4'(hold_dst); ext_bus = glitch;
        @(posedge clk);
        @(negedge clk);
        if (d == 10) chk("R3 ir cleared in clear phase", ir_q, 10'h000);
        ext_bus = fin;
        @(posedge clk);
        @(negedge clk);
        copy_req = 1'b0; ext_bus = '0;
        chk("R2 busy in hold phase", 10'(busy), 10'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R2 busy low after three cycles", 10'(busy), 10'd0);
        if (d >= 1 && d <= 12) m[d] = v;
        if (d == 13) begin m_sig = 1'b1; m_hex = 1'b0; end
        if (d == 14) m_hex = 1'b1;
        if (d == 15) begin m_sig = 1'b0; m_hex = 1'b0; end
    endtask

    task automatic read_reg(input int c, output logic [9:0] val);
        @(negedge clk);
        src_code = 4'(c); dst_code = 4'd0; copy_req = 1'b1; ext_bus = '0;
        @(posedge clk);
        @(negedge clk);
        copy_req = 1'b0;
        val = bus_out;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reg(input string req, input int c);
        logic [9:0] v;
        if (c == 12) begin
            chk(req, status_q, m[12]);
        end else begin
            read_reg(c, v);
            chk(req, v, m[c]);
        end
    endtask

    task automatic check_flags(input string req);
        chk({req, " R9 nop"}, 10'(nop_flag), 10'(nop_model(m[10])));
        chk({req, " R10 jb"}, 10'(jb_used), 10'(m[8] != 10'h000));
        chk({req, " R7 signed"}, 10'(enc_signed), 10'(m_sig));
        chk({req, " R7 hex"}, 10'(enc_hex), 10'(m_hex));
        chk({req, " ir"}, ir_q, m[10]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] v;
        for (int k = 1; k <= 12; k++) m[k] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ext_bus = 10'h2C3;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 10'(busy), 10'd0);
        chk("R1 status", status_q, 10'h000);
        chk("R1 ir", ir_q, 10'h000);
        chk("R1 nop", 10'(nop_flag), 10'd1);
        chk("R1 jb", 10'(jb_used), 10'd0);
        chk("R1 modes", {8'd0, enc_signed, enc_hex}, 10'd0);
        // R11 idle bus follows ext_bus
        chk("R11 idle bus", bus_out, 10'h2C3);
        ext_bus = '0;
        check_reg("R1 reg a zero", 1);

        // R2 load from bus and copy between registers
        do_copy(0, 1, 10'h155, 10'h155, 1'b0, 0);
        check_reg("R2 load a", 1);
        do_copy(1, 2, 10'h000, 10'h000, 1'b0, 0);
        check_reg("R2 copy a to b", 2);
        do_copy(2, 3, 10'h00A, 10'h00A, 1'b0, 0);
        check_reg("R2 or with ext", 3);

        // R3 glitch in clear cycle is lost
        do_copy(0, 4, 10'h0A5, 10'h3FF, 1'b0, 0);
        check_reg("R3 glitch ignored", 4);
        do_copy(0, 10, 10'h123, 10'h3C0, 1'b0, 0);
        chk("R3 ir final", ir_q, 10'h123);

        // R4 self-copy keeps value
        do_copy(1, 1, 10'h000, 10'h000, 1'b0, 0);
        check_reg("R4 self copy", 1);
        chk("R4 self copy value", m[1], 10'h155);

        // R5 status register reads as zero
        do_copy(0, 12, 10'h2AA, 10'h2AA, 1'b0, 0);
        check_reg("R5 status written", 12);
        do_copy(12, 3, 10'h001, 10'h001, 1'b0, 0);
        check_reg("R5 status source zero", 3);
        chk("R5 expect", m[3], 10'h001);

        // R6 encoder digit groups
        seg_hi = 10'h301; seg_mid = 10'h042; seg_lo = 10'h0F4;
        do_copy(13, 6, 10'h000, 10'h000, 1'b0, 0);
        check_reg("R6 seg_hi", 6);
        do_copy(14, 7, 10'h000, 10'h000, 1'b0, 0);
        check_reg("R6 seg_mid", 7);
        do_copy(15, 11, 10'h000, 10'h000, 1'b0, 0);
        check_reg("R6 seg_lo", 11);

        // R7 encoder modes
        do_copy(0, 14, 10'h000, 10'h000, 1'b0, 0);
        check_flags("R7 d14");
        do_copy(0, 13, 10'h000, 10'h000, 1'b0, 0);
        check_flags("R7 d13");
        do_copy(0, 14, 10'h000, 10'h000, 1'b0, 0);
        do_copy(1, 0, 10'h000, 10'h000, 1'b0, 0);
        check_flags("R7 d0");
        do_copy(0, 15, 10'h000, 10'h000, 1'b0, 0);
        check_flags("R7 d15");

        // R8 request held during busy is ignored
        do_copy(0, 5, 10'h0C3, 10'h0C3, 1'b1, 2);
        check_reg("R8 ignored target b", 2);
        check_reg("R8 accepted target", 5);

        // R9 and R10 flags
        do_copy(0, 10, 10'h3FF, 10'h3FF, 1'b0, 0);
        check_flags("R9 all ones");
        do_copy(0, 10, 10'h001, 10'h001, 1'b0, 0);
        check_flags("R9 single bit");
        do_copy(0, 10, 10'h000, 10'h000, 1'b0, 0);
        check_flags("R9 zero");
        do_copy(0, 8, 10'h200, 10'h200, 1'b0, 0);
        check_flags("R10 jb set");
        do_copy(0, 8, 10'h000, 10'h000, 1'b0, 0);
        check_flags("R10 jb clear");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            int s;
            int d;
            logic [9:0] fin;
            logic [9:0] gl;
            s = int'($urandom_range(0, 15));
            d = int'($urandom_range(0, 15));
            fin = 10'($urandom_range(0, 1023));
            if ($urandom_range(0, 3) == 0) fin = '0;
            gl = 10'($urandom_range(0, 1023));
            seg_hi = 10'($urandom_range(0, 1023));
            seg_mid = 10'($urandom_range(0, 1023));
            seg_lo = 10'($urandom_range(0, 1023));
            do_copy(s, d, fin, gl, 1'b0, 0);
            if (d >= 1 && d <= 12) check_reg("R2 random dest", d);
            check_flags("R2 random flags");
        end

        // R11 idle bus again
        @(negedge clk);
        ext_bus = 10'h1E7;
        #1;
        chk("R11 idle bus end", bus_out, 10'h1E7);
        ext_bus = '0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule